// File: doc/BRIEF.md
# Time Base and Decrementer Unit

This block keeps two independent 64-bit up-counters, a primary time base and an alternate time base, and a 32-bit down-counting decrementer. All three move on a shared one-cycle `tick` enable. While `freeze` is high, none of the counters moves and each keeps its value. When `freeze` drops, counting resumes from the held values, so the count does not jump.

The decrementer raises a sticky exception request, `dec_irq`, when it passes below zero. A software write that turns its sign bit from clear to set also raises the request. Only `irq_ack` clears it. `embedded_mode` picks one of two behaviours:

- **Classic mode:** the count wraps from zero to all ones and keeps counting through negative values.
- **Embedded mode:** the request fires on the step from one to zero, and the count then holds at zero.

Software reaches the registers through one request channel with valid/ready and one read-response channel with valid/ready:

- A request is accepted on a cycle where `req_valid` and `req_ready` are both high.
- `req_ready` is high when no response is waiting, or when the waiting response is taken in the same cycle. A stalled response therefore stops new requests.
- An accepted read returns the register value from the cycle of acceptance. The value appears on `rsp_data` with `rsp_valid` one cycle later. It stays there unchanged until `rsp_ready` is seen high.
- Writes produce no response.

Top module: `timebase_decr`

## Requirements
- R1: After reset, both time bases read 0, the decrementer reads 0xFFFFFFFF, `dec_irq` is 0 and `rsp_valid` is 0.
- R2: On each cycle with `tick` high and `freeze` low, the primary and alternate time bases each advance by one, with carry from the low word into the high word.
- R3: Select codes are: 0 primary low word, 1 primary high word, 2 alternate low word, 3 alternate high word, 4 decrementer, 5 masked primary low word. A write to a low word replaces only bits 31:0 and keeps the high word. A write to a high word replaces only bits 63:32 and keeps the low word. The two time bases are independent. A write wins over a tick in the same cycle.
- R4: While `freeze` is high, both time bases and the decrementer hold their values. After release they continue from the held values.
- R5: In classic mode (`embedded_mode`=0), the decrementer decreases by one per step. A step at zero loads 0xFFFFFFFF and sets `dec_irq`.
- R6: In embedded mode (`embedded_mode`=1), a step from 1 to 0 sets `dec_irq`. Further steps at zero keep the count at 0 and raise no new request.
- R7: A software write to the decrementer sets `dec_irq` when bit 31 of the written value is 1 and bit 31 of the old count is 0. Any other write leaves `dec_irq` unchanged.
- R8: `dec_irq` stays set until a cycle with `irq_ack` high. An expiry in the same cycle as `irq_ack` leaves it set.
- R9: Select 5 reads the primary low word ANDed with 0x3FFFFF80. A write through select 5 stores the written value ANDed with 0x3FFFFF80 into the primary low word.
- R10: A read response stays valid, with stable data, until `rsp_ready` is seen high. `req_ready` is low while a response is stalled. Writes produce no response.
- R11: Select codes 6 and 7 read as 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one step per high cycle |
| freeze | input | 1 | Holds all counters while high |
| embedded_mode | input | 1 | 1 selects stop-at-zero decrementer behaviour |
| irq_ack | input | 1 | Clears the exception request |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 3 | Register select code |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_data | output | 32 | Read data |
| dec_irq | output | 1 | Sticky decrementer exception request |

## Verification
A wrong decrementer state shows on `dec_irq` in the cycle after the faulty step. If a wrap is missed, the request never rises. If the count slips below zero in embedded mode, a readback of select 4 is non-zero. A half-word merge that clobbers the other half shows on the next read of that half, one cycle after acceptance. A counter that moves while frozen shows as a changed readback right after the freeze window. A lost response handshake shows as `rsp_data` changing, or `req_ready` rising, while a response is stalled.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
  typedef enum logic [2:0] {
    SEL_TB_LO  = 3'd0,
    SEL_TB_HI  = 3'd1,
    SEL_ATB_LO = 3'd2,
    SEL_ATB_HI = 3'd3,
    SEL_DEC    = 3'd4,
    SEL_RTC_LO = 3'd5
  } sel_e;

  localparam logic [31:0] RTC_LO_MASK = 32'h3FFF_FF80;
  localparam int BASE_COUNT = 2;
endpackage

// File: rtl/tbd_counter64.sv
module tbd_counter64 #(
  parameter int HALF_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [HALF_W-1:0]   wdata,
  output logic [2*HALF_W-1:0] q
);
  localparam int FULL_W = 2 * HALF_W;

  logic [FULL_W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (wr_lo)      nxt = {q[FULL_W-1:HALF_W], wdata};
    else if (wr_hi) nxt = {wdata, q[HALF_W-1:0]};
    else if (step)  nxt = q + {{(FULL_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/tbd_decrementer.sv
module tbd_decrementer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         embedded,
  input  logic         ack,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic         irq
);
  localparam logic [W-1:0] ALL_ONES = '1;
  localparam logic [W-1:0] ZERO     = '0;
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] nxt;
  logic         fire;

  always_comb begin
    nxt  = q;
    fire = 1'b0;
    if (wr) begin
      nxt  = wdata;
      fire = wdata[W-1] && !q[W-1];
    end else if (step) begin
      if (q == ZERO) begin
        if (!embedded) begin
          nxt  = ALL_ONES;
          fire = 1'b1;
        end
      end else begin
        nxt  = q - ONE;
        fire = embedded && (q == ONE);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q   <= ALL_ONES;
      irq <= 1'b0;
    end else begin
      q <= nxt;
      if (fire)     irq <= 1'b1;
      else if (ack) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/tbd_regport.sv
module tbd_regport #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [DATA_W-1:0] rd_value,
  output logic              wr_go,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);
  logic accept;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_go     = accept && req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_value;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/timebase_decr.sv
module timebase_decr
  import tbd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              freeze,
  input  logic              embedded_mode,
  input  logic              irq_ack,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [2:0]        req_sel,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              dec_irq
);
  localparam int BASE_W = 2 * DATA_W;

  logic              step;
  logic              wr_go;
  logic [DATA_W-1:0] rd_value;
  logic [BASE_W-1:0] base_q  [BASE_COUNT];
  logic [DATA_W-1:0] base_wd [BASE_COUNT];
  logic              lo_wr   [BASE_COUNT];
  logic              hi_wr   [BASE_COUNT];
  logic [BASE_W-1:0] tb_q;
  logic [BASE_W-1:0] atb_q;
  logic [DATA_W-1:0] dec_q;
  logic              dec_wr;

  assign step = tick && !freeze;

  // Primary base (index 0) also takes the masked low-word view.
  assign lo_wr[0]   = wr_go && ((req_sel == SEL_TB_LO) || (req_sel == SEL_RTC_LO));
  assign hi_wr[0]   = wr_go && (req_sel == SEL_TB_HI);
  assign base_wd[0] = (req_sel == SEL_RTC_LO) ? (req_wdata & RTC_LO_MASK) : req_wdata;
  assign lo_wr[1]   = wr_go && (req_sel == SEL_ATB_LO);
  assign hi_wr[1]   = wr_go && (req_sel == SEL_ATB_HI);
  assign base_wd[1] = req_wdata;

  generate
    for (genvar gi = 0; gi < BASE_COUNT; gi++) begin : g_base
      tbd_counter64 #(.HALF_W(DATA_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .wr_lo (lo_wr[gi]),
        .wr_hi (hi_wr[gi]),
        .wdata (base_wd[gi]),
        .q     (base_q[gi])
      );
    end
  endgenerate

  assign tb_q  = base_q[0];
  assign atb_q = base_q[1];

  assign dec_wr = wr_go && (req_sel == SEL_DEC);

  tbd_decrementer #(.W(DATA_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .embedded (embedded_mode),
    .ack      (irq_ack),
    .wr       (dec_wr),
    .wdata    (req_wdata),
    .q        (dec_q),
    .irq      (dec_irq)
  );

  always_comb begin
    case (req_sel)
      SEL_TB_LO:  rd_value = tb_q[DATA_W-1:0];
      SEL_TB_HI:  rd_value = tb_q[BASE_W-1:DATA_W];
      SEL_ATB_LO: rd_value = atb_q[DATA_W-1:0];
      SEL_ATB_HI: rd_value = atb_q[BASE_W-1:DATA_W];
      SEL_DEC:    rd_value = dec_q;
      SEL_RTC_LO: rd_value = tb_q[DATA_W-1:0] & RTC_LO_MASK;
      default:    rd_value = '0;
    endcase
  end

  tbd_regport #(.DATA_W(DATA_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .rd_value  (rd_value),
    .wr_go     (wr_go),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data)
  );
endmodule

// File: rtl/tbd_checker.sv
module tbd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        freeze,
  input logic        embedded_mode,
  input logic        ack,
  input logic        wr_go,
  input logic [2:0]  wr_sel,
  input logic [31:0] wr_data,
  input logic [63:0] tb_q,
  input logic [63:0] atb_q,
  input logic [31:0] dec_q,
  input logic        dec_irq,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        req_ready,
  input logic [31:0] rsp_data
);
  logic dec_wr;
  assign dec_wr = wr_go && (wr_sel == 3'd4);

  assert_freeze_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !wr_go) |=> ($stable(tb_q) && $stable(atb_q) && $stable(dec_q)));

  assert_classic_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!embedded_mode && tick && !freeze && !dec_wr && dec_q == 32'd0)
      |=> (dec_irq && dec_q == 32'hFFFF_FFFF));

  assert_embedded_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (embedded_mode && tick && !dec_wr && dec_q == 32'd0) |=> (dec_q == 32'd0));

  assert_sign_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_wr && wr_data[31] && !dec_q[31]) |=> dec_irq);

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_irq && !ack) |=> dec_irq);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_ready_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind timebase_decr tbd_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick          (tick),
  .freeze        (freeze),
  .embedded_mode (embedded_mode),
  .ack           (irq_ack),
  .wr_go         (wr_go),
  .wr_sel        (req_sel),
  .wr_data       (req_wdata),
  .tb_q          (tb_q),
  .atb_q         (atb_q),
  .dec_q         (dec_q),
  .dec_irq       (dec_irq),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .req_ready     (req_ready),
  .rsp_data      (rsp_data)
);

// File: tb/timebase_decr_test.sv
module timebase_decr_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        freeze = 1'b0;
  logic        embedded_mode = 1'b0;
  logic        irq_ack = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [2:0]  req_sel = 3'd0;
  logic [31:0] req_wdata = 32'd0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        dec_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  timebase_decr uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .freeze(freeze),
    .embedded_mode(embedded_mode), .irq_ack(irq_ack),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_sel(req_sel), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .dec_irq(dec_irq)
  );

  // Row layout: {is_write, sel[2:0], data[31:0], expected[31:0]}
  localparam logic [67:0] VEC [NVEC] = '{
    {1'b1, 3'd0, 32'h1234_5678, 32'h0},          // R3 write primary low
    {1'b1, 3'd1, 32'hDEAD_BEEF, 32'h0},          // R3 write primary high
    {1'b0, 3'd0, 32'h0,         32'h1234_5678},  // R3 low read back
    {1'b0, 3'd1, 32'h0,         32'hDEAD_BEEF},  // R3 high read back
    {1'b1, 3'd0, 32'h0,         32'h0},          // R3 low write again
    {1'b0, 3'd1, 32'h0,         32'hDEAD_BEEF},  // R3 high kept
    {1'b1, 3'd2, 32'hCAFE_F00D, 32'h0},          // R3 alternate low
    {1'b0, 3'd2, 32'h0,         32'hCAFE_F00D},  // R3
    {1'b0, 3'd0, 32'h0,         32'h0},          // R3 primary untouched
    {1'b1, 3'd5, 32'hFFFF_FFFF, 32'h0},          // R9 masked write
    {1'b0, 3'd0, 32'h0,         32'h3FFF_FF80},  // R9
    {1'b0, 3'd5, 32'h0,         32'h3FFF_FF80},  // R9 masked read
    {1'b1, 3'd6, 32'h1111_1111, 32'h0},          // R11 ignored write
    {1'b0, 3'd6, 32'h0,         32'h0},          // R11 reads zero
    {1'b0, 3'd0, 32'h0,         32'h3FFF_FF80},  // R11 nothing changed
    {1'b1, 3'd4, 32'h0000_0007, 32'h0}           // R7 sign stays clear
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_sel = sel; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] sel, output logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_sel = sel;
    @(negedge clk);
    req_valid = 1'b0;
    data = rsp_valid ? rsp_data : 32'hBAD0_BAD0;
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic pulse_ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", {31'd0, dec_irq}, 32'd0);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    for (int s = 0; s < 4; s++) begin
      do_read(3'(s), v); check("R1 base", v, 32'd0);
    end
    do_read(3'd4, v); check("R1 dec", v, 32'hFFFF_FFFF);

    // Vector table (tick held low)
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][67]) do_write(VEC[i][66:64], VEC[i][63:32]);
      else begin
        do_read(VEC[i][66:64], v);
        check($sformatf("R3/R9/R11 row %0d", i), v, VEC[i][31:0]);
      end
    end
    check("R7 no fire on clear sign", {31'd0, dec_irq}, 32'd0);

    // R2 carry and both bases advance
    do_write(3'd0, 32'hFFFF_FFFE); do_write(3'd1, 32'd0);
    do_write(3'd2, 32'd0);         do_write(3'd3, 32'd5);
    do_ticks(3);
    do_read(3'd0, v); check("R2 tb lo", v, 32'd1);
    do_read(3'd1, v); check("R2 tb hi carry", v, 32'd1);
    do_read(3'd2, v); check("R2 atb lo", v, 32'd3);
    do_read(3'd3, v); check("R2 atb hi", v, 32'd5);

    // R4 freeze
    do_write(3'd4, 32'd100);
    @(negedge clk); freeze = 1'b1;
    do_ticks(5);
    do_read(3'd0, v); check("R4 tb held", v, 32'd1);
    do_read(3'd4, v); check("R4 dec held", v, 32'd100);
    @(negedge clk); freeze = 1'b0;
    do_ticks(2);
    do_read(3'd0, v); check("R4 tb resumed", v, 32'd3);
    do_read(3'd2, v); check("R4 atb resumed", v, 32'd5);
    do_read(3'd4, v); check("R4 dec resumed", v, 32'd98);

    // R5 classic wrap
    do_write(3'd4, 32'd1);
    do_ticks(1);
    check("R5 no irq at zero", {31'd0, dec_irq}, 32'd0);
    do_ticks(1);
    check("R5 irq on wrap", {31'd0, dec_irq}, 32'd1);
    do_read(3'd4, v); check("R5 reload", v, 32'hFFFF_FFFF);
    do_ticks(1);
    do_read(3'd4, v); check("R5 keeps counting", v, 32'hFFFF_FFFE);

    // R8 sticky and ack collision
    do_ticks(2);
    check("R8 sticky", {31'd0, dec_irq}, 32'd1);
    pulse_ack();
    check("R8 ack clears", {31'd0, dec_irq}, 32'd0);
    do_write(3'd4, 32'd0);
    @(negedge clk); tick = 1'b1; irq_ack = 1'b1;
    @(negedge clk); tick = 1'b0; irq_ack = 1'b0;
    check("R8 expiry beats ack", {31'd0, dec_irq}, 32'd1);
    pulse_ack();

    // R6 embedded floor
    embedded_mode = 1'b1;
    do_write(3'd4, 32'd2);
    do_ticks(1);
    check("R6 no irq at one", {31'd0, dec_irq}, 32'd0);
    do_ticks(1);
    check("R6 irq reaching zero", {31'd0, dec_irq}, 32'd1);
    pulse_ack();
    do_ticks(3);
    do_read(3'd4, v); check("R6 held at zero", v, 32'd0);
    check("R6 no repeat irq", {31'd0, dec_irq}, 32'd0);
    embedded_mode = 1'b0;

    // R7 sign transition by write
    do_write(3'd4, 32'd5);
    do_write(3'd4, 32'h8000_0000);
    check("R7 write sets sign", {31'd0, dec_irq}, 32'd1);
    pulse_ack();
    do_write(3'd4, 32'h9000_0000);
    check("R7 sign already set", {31'd0, dec_irq}, 32'd0);

    // R10 back-pressure
    do_write(3'd4, 32'h0001_2345);
    check("R10 write no response", {31'd0, rsp_valid}, 32'd0);
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_write = 1'b0; req_sel = 3'd4;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 rsp valid", {31'd0, rsp_valid}, 32'd1);
    check("R10 rsp data", rsp_data, 32'h0001_2345);
    check("R10 ready low", {31'd0, req_ready}, 32'd0);
    req_valid = 1'b1; req_sel = 3'd0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 held valid", {31'd0, rsp_valid}, 32'd1);
    check("R10 held data", rsp_data, 32'h0001_2345);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R10 drained", {31'd0, rsp_valid}, 32'd0);

    finish_run();
  end
endmodule